// File: doc/BRIEF.md
# Multi-Word Program-and-Verify Sequencer

This block runs a bulk programming command against a small word-addressed storage array split into equal-size blocks. A start pulse opens the command. The first bus write fixes the start location and supplies the first word. Each later bus write that lands inside the start block supplies the next word, and that word goes to the next location in sequence whatever address came with it. A write to any address outside the start block closes the phase.

The first phase programs the words. Programming can only clear bits. The second phase is a compulsory verify pass. The host sends the same words again, and each one is compared with the stored word. A stored word that differs is reprogrammed and checked again until it matches or a retry budget runs out. A stuck-bit mask input lets a test force cells that never clear, so the failure path can be reached.

While a command is open, bus reads return a status word instead of array data. If a reprogram fails, the block stays in a fault state and keeps returning status until a read/reset pulse arrives. The supply level is a single flag input.

Top module: `mwp_sequencer`

## Requirements
- R1: After reset every array word reads as all ones. In read mode, a read strobe returns the array word at the given address on `bus_rdata` in the following cycle.
- R2: A `cmd_go` pulse in read mode opens the program phase. From then on, a read strobe returns the status word on `bus_rdata` in the following cycle. Status bit 0 is ready, and it is 1 while no word is being processed.
- R3: The first write of a phase stores its data at its own address. Each later write inside the same block (blocks are 2^BLK_W words, aligned) stores at the previous location plus one, wrapping within the block, whatever address is presented.
- R4: A write outside the start block, made while ready, ends the current phase and stores nothing. Ending the program phase opens the verify phase, and ready stays 1. Ending the verify phase returns the block to read mode.
- R5: After a word is accepted, status bit 0 reads 0 for PROG_CYC cycles. A write made while bit 0 is 0 is dropped and sets status bit 3 (overrun). Bit 3 stays set until the next `cmd_go`.
- R6: A program write leaves the stored word equal to the old word ANDed with the new word, with bits in `stuck_mask` held at 1.
- R7: In the verify phase, a resent word that differs from the stored word is reprogrammed. Ready stays 0 until the stored word matches, and then the phase continues.
- R8: If a word still differs after MAX_RETRY reprogram attempts, the block enters the fault state. Status then shows bit 5 set, bit 4 clear and bit 0 clear, and writes are ignored.
- R9: If a reprogram is needed while `supply_ok` is 0, the block faults with both bit 5 and bit 4 set. A program write made while `supply_ok` is 0 leaves the cell unchanged.
- R10: Status bit 6 inverts after every status read while a phase is open. In the fault state it holds its value.
- R11: `cmd_go` and `cmd_rr` have no effect while a phase is open. In the fault state, `cmd_rr` returns the block to read mode and clears bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Pulse that opens a bulk program command |
| cmd_rr | input | 1 | Read/reset pulse that clears the fault state |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data or status word, valid the cycle after `bus_re` |
| supply_ok | input | 1 | Programming supply is in range |
| stuck_mask | input | DW | Test hook: bits whose cells cannot be cleared |

## Verification
The bound checker watches properties that must hold on every cycle:
- ready drops after the first word of a phase;
- the overrun flag stays set while a phase is open;
- the fault state holds until `cmd_rr`, and ready stays low in it;
- bit 4 never shows without bit 5;
- the toggle bit inverts on each status read during a phase and is frozen in the fault state;
- a phase never falls back to read mode without a write.

Other behaviours need the bench's scenarios: the auto-increment placement of words, the AND-only programming, a successful reprogram after a supply dip, exhaustion of the retry budget through a stuck bit, and the stored data seen after read mode resumes.

// File: rtl/mwp_pkg.sv
// Shared types and status bit positions for the multi-word program sequencer.
package mwp_pkg;

    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_PFIRST = 3'd1,
        ST_PRUN   = 3'd2,
        ST_VFIRST = 3'd3,
        ST_VRUN   = 3'd4,
        ST_FAIL   = 3'd5
    } mwp_state_e;

    localparam int SB_READY = 0;
    localparam int SB_OVR   = 3;
    localparam int SB_VPP   = 4;
    localparam int SB_ERR   = 5;
    localparam int SB_TGL   = 6;

    // True while a program or verify phase is open.
    function automatic logic is_active(mwp_state_e s);
        return (s == ST_PFIRST) || (s == ST_PRUN) || (s == ST_VFIRST) || (s == ST_VRUN);
    endfunction

endpackage

// File: rtl/mwp_array.sv
// Storage array with AND-only writes.
// Two combinational read ports: one for the bus, one for verify compares.
// Assumes at most one write per cycle. Reset sets every cell to all ones.
module mwp_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [AW-1:0] cmp_addr,
    output logic [DW-1:0] cmp_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] stuck_mask
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rd_data  = mem[rd_addr];
    assign cmp_data = mem[cmp_addr];

    // Clear-only update: bits in stuck_mask never leave 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & (wr_data | stuck_mask);
        end
    end
endmodule

// File: rtl/mwp_ctrl.sv
// Phase controller: program, verify, and the fault state.
// Tracks the start block and the running location, the busy counter,
// the reprogram retries and the sticky flags.
// Assumes the array write lands at the clock edge after the request.
module mwp_ctrl
    import mwp_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int BLK_W     = 4,
    parameter int PROG_CYC  = 3,
    parameter int MAX_RETRY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic          cmd_rr,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          supply_ok,
    input  logic [DW-1:0] cmp_data,
    output logic [AW-1:0] cmp_addr,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output mwp_state_e    state,
    output logic          rdy,
    output logic          ovr,
    output logic          err,
    output logic          vpp
);
    localparam int BW = AW - BLK_W;
    localparam int CW = $clog2(PROG_CYC + 1);
    localparam int TW = $clog2(MAX_RETRY + 1);

    mwp_state_e    st_q, st_n;
    logic [BW-1:0] blk_q, blk_n;
    logic [AW-1:0] tgt_q, tgt_n;
    logic [DW-1:0] word_q, word_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [TW-1:0] tries_q, tries_n;
    logic          recheck_q, recheck_n;
    logic          ovr_q, ovr_n, err_q, err_n, vpp_q, vpp_n;
    logic          first_w, verify_w, in_blk;
    logic [AW-1:0] place;

    assign in_blk   = (bus_addr[AW-1:BLK_W] == blk_q);
    assign first_w  = (st_q == ST_PFIRST) || (st_q == ST_VFIRST);
    assign verify_w = (st_q == ST_VFIRST) || (st_q == ST_VRUN);
    assign place    = first_w ? bus_addr : {blk_q, BLK_W'(tgt_q[BLK_W-1:0] + 1'b1)};

    // Next-state decisions for phases, busy time, retries and flags.
    always_comb begin
        st_n      = st_q;
        blk_n     = blk_q;
        tgt_n     = tgt_q;
        word_n    = word_q;
        cnt_n     = cnt_q;
        tries_n   = tries_q;
        recheck_n = recheck_q;
        ovr_n     = ovr_q;
        err_n     = err_q;
        vpp_n     = vpp_q;
        arr_we    = 1'b0;
        arr_waddr = tgt_q;
        arr_wdata = word_q;
        cmp_addr  = tgt_q;
        case (st_q)
            ST_READ: begin
                if (cmd_go) begin
                    st_n  = ST_PFIRST;
                    ovr_n = 1'b0;
                end
            end
            ST_FAIL: begin
                if (cmd_rr) begin
                    st_n  = ST_READ;
                    err_n = 1'b0;
                    vpp_n = 1'b0;
                end
            end
            default: begin
                if (cnt_q != '0) begin
                    if (bus_we) ovr_n = 1'b1;
                    if (recheck_q && cnt_q == CW'(1)) begin
                        if (cmp_data == word_q) begin
                            cnt_n     = '0;
                            recheck_n = 1'b0;
                        end else if (tries_q == TW'(MAX_RETRY)) begin
                            st_n      = ST_FAIL;
                            err_n     = 1'b1;
                            cnt_n     = '0;
                            recheck_n = 1'b0;
                        end else if (!supply_ok) begin
                            st_n      = ST_FAIL;
                            err_n     = 1'b1;
                            vpp_n     = 1'b1;
                            cnt_n     = '0;
                            recheck_n = 1'b0;
                        end else begin
                            arr_we  = 1'b1;
                            cnt_n   = CW'(PROG_CYC);
                            tries_n = tries_q + 1'b1;
                        end
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end else if (bus_we) begin
                    if (!first_w && !in_blk) begin
                        st_n = verify_w ? ST_READ : ST_VFIRST;
                    end else begin
                        tgt_n    = place;
                        word_n   = bus_wdata;
                        cmp_addr = place;
                        if (first_w) blk_n = bus_addr[AW-1:BLK_W];
                        st_n = verify_w ? ST_VRUN : ST_PRUN;
                        arr_waddr = place;
                        arr_wdata = bus_wdata;
                        if (!verify_w) begin
                            arr_we = supply_ok;
                            cnt_n  = CW'(PROG_CYC);
                        end else if (cmp_data == bus_wdata) begin
                            cnt_n = CW'(1);
                        end else if (!supply_ok) begin
                            st_n  = ST_FAIL;
                            err_n = 1'b1;
                            vpp_n = 1'b1;
                        end else begin
                            arr_we    = 1'b1;
                            cnt_n     = CW'(PROG_CYC);
                            tries_n   = TW'(1);
                            recheck_n = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    // State register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_READ;
            blk_q     <= '0;
            tgt_q     <= '0;
            word_q    <= '0;
            cnt_q     <= '0;
            tries_q   <= '0;
            recheck_q <= 1'b0;
            ovr_q     <= 1'b0;
            err_q     <= 1'b0;
            vpp_q     <= 1'b0;
        end else begin
            st_q      <= st_n;
            blk_q     <= blk_n;
            tgt_q     <= tgt_n;
            word_q    <= word_n;
            cnt_q     <= cnt_n;
            tries_q   <= tries_n;
            recheck_q <= recheck_n;
            ovr_q     <= ovr_n;
            err_q     <= err_n;
            vpp_q     <= vpp_n;
        end
    end

    assign state = st_q;
    assign rdy   = is_active(st_q) && (cnt_q == '0);
    assign ovr   = ovr_q;
    assign err   = err_q;
    assign vpp   = vpp_q;
endmodule

// File: rtl/mwp_status.sv
// Read path: registers array data in read mode and the status word otherwise.
// Flips the toggle bit after each status read while a phase is open.
// Assumes DW is at least 7 so that every status bit fits.
module mwp_status
    import mwp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_re,
    input  mwp_state_e    state,
    input  logic          rdy,
    input  logic          ovr,
    input  logic          err,
    input  logic          vpp,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rdata,
    output logic          tgl
);
    logic [DW-1:0] sw;

    // Assemble the status word from the live flags.
    always_comb begin
        sw           = '0;
        sw[SB_READY] = rdy;
        sw[SB_OVR]   = ovr;
        sw[SB_VPP]   = vpp;
        sw[SB_ERR]   = err;
        sw[SB_TGL]   = tgl;
    end

    // Capture read data and advance the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tgl   <= 1'b0;
        end else if (bus_re) begin
            if (state == ST_READ) begin
                rdata <= arr_data;
            end else begin
                rdata <= sw;
                if (is_active(state)) tgl <= ~tgl;
            end
        end
    end
endmodule

// File: rtl/mwp_sequencer.sv
// Top level: multi-word program-and-verify sequencer.
// Connects the controller, the storage array and the read path.
// Assumes the bus strobes are synchronous to clk.
module mwp_sequencer
    import mwp_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int BLK_W     = 4,
    parameter int PROG_CYC  = 3,
    parameter int MAX_RETRY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic          cmd_rr,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          supply_ok,
    input  logic [DW-1:0] stuck_mask
);
    mwp_state_e    state_w;
    logic          rdy_w, ovr_w, err_w, vpp_w, tgl_w, arr_we;
    logic [AW-1:0] cmp_addr, arr_waddr;
    logic [DW-1:0] cmp_data, arr_wdata, rd_data;

    mwp_ctrl #(
        .AW(AW), .DW(DW), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .MAX_RETRY(MAX_RETRY)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_rr(cmd_rr),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .supply_ok(supply_ok), .cmp_data(cmp_data), .cmp_addr(cmp_addr),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .state(state_w), .rdy(rdy_w), .ovr(ovr_w), .err(err_w), .vpp(vpp_w)
    );

    mwp_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_data(rd_data),
        .cmp_addr(cmp_addr), .cmp_data(cmp_data), .wr_en(arr_we),
        .wr_addr(arr_waddr), .wr_data(arr_wdata), .stuck_mask(stuck_mask)
    );

    mwp_status #(.DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .state(state_w),
        .rdy(rdy_w), .ovr(ovr_w), .err(err_w), .vpp(vpp_w),
        .arr_data(rd_data), .rdata(bus_rdata), .tgl(tgl_w)
    );
endmodule

// File: rtl/mwp_checker.sv
// Cycle-level properties of the sequencer, bound to the top module.
module mwp_checker
    import mwp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic       bus_re,
    input logic       cmd_rr,
    input mwp_state_e state_w,
    input logic       rdy_w,
    input logic       ovr_w,
    input logic       err_w,
    input logic       vpp_w,
    input logic       tgl_w
);
    p_first_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_w && bus_we && (state_w == ST_PFIRST || state_w == ST_VFIRST)) |=> !rdy_w);

    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_w && state_w != ST_READ) |=> ovr_w);

    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_FAIL && !cmd_rr) |=> state_w == ST_FAIL);

    p_fail_notready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_FAIL) |-> !rdy_w);

    p_vpp_with_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_w |-> err_w);

    p_tgl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_FAIL) |=> $stable(tgl_w));

    p_tgl_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && is_active(state_w)) |=> tgl_w != $past(tgl_w));

    p_no_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_active(state_w) && !bus_we) |=> state_w != ST_READ);

    p_read_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_READ) |-> (!err_w && !vpp_w));
endmodule

bind mwp_sequencer mwp_checker u_mwp_checker (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .cmd_rr(cmd_rr),
    .state_w(state_w), .rdy_w(rdy_w), .ovr_w(ovr_w), .err_w(err_w),
    .vpp_w(vpp_w), .tgl_w(tgl_w)
);

// File: tb/test_mwp_sequencer.sv
module test_mwp_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0, cmd_rr = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       supply_ok = 1'b1;
    logic [7:0] stuck_mask = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic chk_en = 1'b0;
    logic re_q = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    mwp_sequencer i_mwp_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_rr(cmd_rr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .supply_ok(supply_ok), .stuck_mask(stuck_mask)
    );

    // Monitor: pops expected items when a checked read completes.
    always @(posedge clk) re_q <= bus_re && chk_en;
    always @(negedge clk) begin
        if (re_q && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (mask %h)",
                         it.tag, bus_rdata & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Tasks start and end at a falling edge.
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [7:0] e,
                          input logic [7:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.tag = tag;
        sb.push_back(it);
        bus_re = 1'b1; chk_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0; chk_en = 1'b0;
    endtask

    task automatic poll(output logic [7:0] s);
        bus_re = 1'b1; chk_en = 1'b0;
        @(negedge clk);
        bus_re = 1'b0;
        s = bus_rdata;
    endtask

    task automatic wait_rdy(output logic [7:0] s);
        for (int i = 0; i < 80; i++) begin
            poll(s);
            if (s[0] || s[5]) break;
        end
    endtask

    task automatic pulse_go();
        cmd_go = 1'b1; @(negedge clk); cmd_go = 1'b0;
    endtask

    task automatic pulse_rr();
        cmd_rr = 1'b1; @(negedge clk); cmd_rr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased array readable in read mode
        rd_chk(6'd5, 8'hFF, 8'hFF, "R1 reset array");

        // Scenario A: placement, busy, overrun, phase changes
        pulse_go();
        rd_chk(6'd0, 8'h01, 8'h39, "R2 status ready after go");
        wr(6'd17, 8'hA1);
        rd_chk(6'd0, 8'h00, 8'h01, "R5 busy after word");
        wr(6'd20, 8'h77);
        wait_rdy(s);
        rd_chk(6'd0, 8'h09, 8'h09, "R5 overrun set");
        poll(s); poll(s2);
        check(s[6] != s2[6], "R10 toggle flips", s2[6], ~s[6]);
        wr(6'd31, 8'hB2); wait_rdy(s);
        wr(6'd16, 8'hC3); wait_rdy(s);
        wr(6'd2, 8'h00);
        rd_chk(6'd0, 8'h01, 8'h01, "R4 verify phase ready");
        wr(6'd17, 8'hA1); wait_rdy(s);
        pulse_go(); pulse_rr();
        rd_chk(6'd0, 8'h09, 8'h09, "R11 go/rr ignored while active");
        wr(6'd17, 8'hB2); wait_rdy(s);
        wr(6'd17, 8'hC3); wait_rdy(s);
        wr(6'd40, 8'h00);
        rd_chk(6'd17, 8'hA1, 8'hFF, "R3 first word");
        rd_chk(6'd18, 8'hB2, 8'hFF, "R3 auto-increment");
        rd_chk(6'd19, 8'hC3, 8'hFF, "R3 auto-increment");
        rd_chk(6'd20, 8'hFF, 8'hFF, "R5 dropped word not stored");
        rd_chk(6'd2, 8'hFF, 8'hFF, "R4 exit write stores nothing");

        // Scenario B: AND-only programming
        pulse_go();
        rd_chk(6'd0, 8'h01, 8'h09, "R5 overrun cleared by go");
        wr(6'd32, 8'hF0); wait_rdy(s); wr(6'd0, 8'h00);
        wr(6'd32, 8'hF0); wait_rdy(s); wr(6'd0, 8'h00);
        pulse_go();
        wr(6'd32, 8'h3C); wait_rdy(s); wr(6'd0, 8'h00);
        wr(6'd32, 8'h30); wait_rdy(s);
        check(s[5] == 1'b0, "R6 verify of AND result passes", s[5], 0);
        wr(6'd0, 8'h00);
        rd_chk(6'd32, 8'h30, 8'hFF, "R6 AND of old and new");

        // Scenario C: reprogram after a supply dip
        supply_ok = 1'b0;
        pulse_go();
        wr(6'd40, 8'h5A); wait_rdy(s); wr(6'd0, 8'h00);
        supply_ok = 1'b1;
        wr(6'd40, 8'h5A);
        rd_chk(6'd0, 8'h00, 8'h21, "R7 busy during reprogram");
        wait_rdy(s);
        check(s[5:0] == 6'h01, "R7 reprogram succeeds", s[5:0], 1);
        wr(6'd0, 8'h00);
        rd_chk(6'd40, 8'h5A, 8'hFF, "R7 stored after reprogram");

        // Scenario D: stuck bit exhausts the retry budget
        stuck_mask = 8'h01;
        pulse_go();
        wr(6'd48, 8'h00); wait_rdy(s); wr(6'd0, 8'h00);
        wr(6'd48, 8'h00);
        wait_rdy(s);
        rd_chk(6'd0, 8'h20, 8'h31, "R8 fault status");
        poll(s); poll(s2);
        check(s[6] == s2[6], "R10 toggle frozen in fault", s2[6], s[6]);
        wr(6'd48, 8'h00);
        pulse_go();
        rd_chk(6'd0, 8'h20, 8'h31, "R8 writes and go ignored in fault");
        pulse_rr();
        rd_chk(6'd48, 8'h01, 8'hFF, "R11 read/reset returns to read mode");
        stuck_mask = 8'h00;

        // Scenario E: supply fault during verify
        supply_ok = 1'b0;
        pulse_go();
        wr(6'd56, 8'h12); wait_rdy(s); wr(6'd0, 8'h00);
        wr(6'd56, 8'h12);
        rd_chk(6'd0, 8'h30, 8'h31, "R9 supply fault status");
        pulse_rr();
        supply_ok = 1'b1;
        rd_chk(6'd56, 8'hFF, 8'hFF, "R9 cell unchanged under low supply");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule